// File: doc/BRIEF.md
# Guarded PLL Configuration Register

This block is the software-visible configuration word for one phase-locked loop. A simple register bus writes a full 32-bit word when `wr_en` is high and reads the stored fields back on `rd_data` at all times. The word holds a reference source selector, an input frequency range, a fractional latch enable, an input prescaler, a booster prescaler and three output-divider enables. The outputs go to the analog core, the dividers and the fractional modulator, which are outside this block.

Each field has its own write qualification, based on four live status inputs: PLL on, PLL ready, booster mode active, and PLL selected as the system clock. The lock is evaluated with the status values present in the same cycle as the bus write. A field that is locked keeps its old value, and the rest of the same write still lands. A 0-to-1 change of the fractional latch enable produces a registered, single-cycle load strobe toward the fractional modulator.

Top module: `pllcfg_guard_reg`

## Requirements
- R1: After reset every field is 0, `rd_data` is 0, `frac_load` is low, the prescaler ratio reads 1 and the booster ratio reads 1.
- R2: The bit layout is: source at bits 1:0, range at bits 3:2, fractional enable at bit 4, input prescaler at bits 11:8, booster prescaler at bits 15:12, and P/Q/R enables at bits 16/17/18. `rd_data` returns the stored fields, and every other bit reads 0.
- R3: The source field (0 = no clock; 1, 2, 3 = three reference oscillators) is written only when `st_pll_on` is low. Otherwise it keeps its value.
- R4: The input prescaler is written only when `st_pll_on` and `st_pll_rdy` are both low. `pre_div_ratio` equals code+1, so 0 gives 1 and 15 gives 16.
- R5: The booster prescaler is written only when `st_pll_on`, `st_pll_rdy` and `st_boost_mode` are all low. `boost_div_ratio` is 1 for code 0 and 2×code for codes 1 to 8. Codes 9 to 15 are reserved and give 0.
- R6: The range field is always writable. `range_hi` is 1 only for code 3 (8–16 MHz reference); codes 0 to 2 give 0.
- R7: `frac_load` is high for exactly one cycle, the cycle after a write that moves the fractional enable from 0 to 1. A write that leaves it at 1, or that clears it, gives no pulse.
- R8: The P and Q enables (1 = output on) can be set and cleared by any write.
- R9: The R enable can always be set. A clear is ignored while `st_sysclk_sel` is high.
- R10: Each lock uses the status inputs sampled at the clock edge of the write. A status change in the cycle after a write does not affect that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Bus write word |
| rd_data | output | 32 | Stored configuration word |
| st_pll_on | input | 1 | PLL enabled status |
| st_pll_rdy | input | 1 | PLL locked/ready status |
| st_boost_mode | input | 1 | Booster mode active status |
| st_sysclk_sel | input | 1 | PLL currently drives the system clock |
| ref_src | output | 2 | Reference source code |
| range_hi | output | 1 | High input range selected |
| pre_div_ratio | output | 5 | Input prescaler division ratio |
| boost_div_ratio | output | 5 | Booster prescaler division ratio (0 = reserved code) |
| frac_load | output | 1 | One-cycle fractional load strobe |
| out_en_p | output | 1 | P divider output enable |
| out_en_q | output | 1 | Q divider output enable |
| out_en_r | output | 1 | R divider output enable |

## Verification
The bench tests each lock one status input at a time. With only ready high, the source must change but the prescaler must not. With only booster mode high, the input prescaler must change but the booster prescaler must not. A design with the conditions swapped or merged would let a locked field move or freeze a free one. Repeated writes of 1 to the fractional enable check that the strobe fires only on the 0-to-1 edge; a level-sensitive design would pulse again. The bench also writes the booster codes at the edge of the reserved range, tries to clear the R enable while it is the system clock, and writes all ones to check that reserved bits read 0 and that locked and unlocked fields in one word are handled separately.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int REG_W    = 32;
    localparam int SRC_W    = 2;
    localparam int RNG_W    = 2;
    localparam int PRE_W    = 4;
    localparam int BST_W    = 4;
    localparam int NUM_OUT  = 3;
    localparam int OUT_R    = 2;
    localparam int BST_MAX  = 8;

    localparam int SRC_LSB  = 0;
    localparam int RNG_LSB  = 2;
    localparam int FRAC_BIT = 4;
    localparam int PRE_LSB  = 8;
    localparam int BST_LSB  = 12;
    localparam int OEN_LSB  = 16;

    localparam int PRE_RATIO_W = PRE_W + 1;
    localparam int BST_RATIO_W = $clog2(2 * BST_MAX + 1);
    localparam logic [RNG_W-1:0] RNG_HIGH_CODE = '1;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE  = 2'd0,
        SRC_OSC_A = 2'd1,
        SRC_OSC_B = 2'd2,
        SRC_OSC_C = 2'd3
    } src_e;

    typedef struct packed {
        logic [NUM_OUT-1:0] oen;
        logic [BST_W-1:0]   bst;
        logic [PRE_W-1:0]   pre;
        logic               frac_en;
        logic [RNG_W-1:0]   rng;
        src_e               src;
    } cfg_t;

    typedef struct packed {
        logic pll_on;
        logic pll_rdy;
        logic boost_mode;
        logic sysclk_sel;
    } status_t;

    typedef struct packed {
        logic               src;
        logic               rng;
        logic               frac;
        logic               pre;
        logic               bst;
        logic [NUM_OUT-1:0] oen_set;
        logic [NUM_OUT-1:0] oen_clr;
    } wperm_t;

    function automatic cfg_t word_to_cfg(input logic [REG_W-1:0] d);
        cfg_t c;
        c.src     = src_e'(d[SRC_LSB +: SRC_W]);
        c.rng     = d[RNG_LSB +: RNG_W];
        c.frac_en = d[FRAC_BIT];
        c.pre     = d[PRE_LSB +: PRE_W];
        c.bst     = d[BST_LSB +: BST_W];
        c.oen     = d[OEN_LSB +: NUM_OUT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input cfg_t c);
        logic [REG_W-1:0] d;
        d = '0;
        d[SRC_LSB +: SRC_W]   = c.src;
        d[RNG_LSB +: RNG_W]   = c.rng;
        d[FRAC_BIT]           = c.frac_en;
        d[PRE_LSB +: PRE_W]   = c.pre;
        d[BST_LSB +: BST_W]   = c.bst;
        d[OEN_LSB +: NUM_OUT] = c.oen;
        return d;
    endfunction

    function automatic logic [PRE_RATIO_W-1:0] pre_ratio(input logic [PRE_W-1:0] code);
        return PRE_RATIO_W'(code) + PRE_RATIO_W'(1);
    endfunction

    function automatic logic [BST_RATIO_W-1:0] bst_ratio(input logic [BST_W-1:0] code);
        if (code == '0)
            return BST_RATIO_W'(1);
        else if (int'(code) <= BST_MAX)
            return BST_RATIO_W'(code) << 1;
        else
            return '0;
    endfunction

endpackage

// File: rtl/pllcfg_lock_ctrl.sv
module pllcfg_lock_ctrl
    import pllcfg_pkg::*;
(
    input  status_t st,
    output wperm_t  perm
);

    logic               idle_core;
    logic [NUM_OUT-1:0] clr_ok;

    assign idle_core = !st.pll_on && !st.pll_rdy;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_oen_rule
        if (i == OUT_R) begin : g_sys
            assign clr_ok[i] = !st.sysclk_sel;
        end else begin : g_free
            assign clr_ok[i] = 1'b1;
        end
    end

    always_comb begin
        perm.src     = !st.pll_on;
        perm.rng     = 1'b1;
        perm.frac    = 1'b1;
        perm.pre     = idle_core;
        perm.bst     = idle_core && !st.boost_mode;
        perm.oen_set = '1;
        perm.oen_clr = clr_ok;
    end

endmodule

// File: rtl/pllcfg_field_store.sv
module pllcfg_field_store
    import pllcfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  cfg_t   wr_cfg,
    input  wperm_t perm,
    input  logic   sysclk_sel,
    output cfg_t   cfg
);

    src_e               src_q;
    logic [RNG_W-1:0]   rng_q;
    logic               frac_q;
    logic [PRE_W-1:0]   pre_q;
    logic [BST_W-1:0]   bst_q;
    logic [NUM_OUT-1:0] oen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_NONE;
            rng_q  <= '0;
            frac_q <= 1'b0;
            pre_q  <= '0;
            bst_q  <= '0;
        end else if (we) begin
            if (perm.src)  src_q  <= wr_cfg.src;
            if (perm.rng)  rng_q  <= wr_cfg.rng;
            if (perm.frac) frac_q <= wr_cfg.frac_en;
            if (perm.pre)  pre_q  <= wr_cfg.pre;
            if (perm.bst)  bst_q  <= wr_cfg.bst;
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_oen
        always_ff @(posedge clk) begin
            if (rst)
                oen_q[i] <= 1'b0;
            else if (we) begin
                if (wr_cfg.oen[i] && perm.oen_set[i])
                    oen_q[i] <= 1'b1;
                else if (!wr_cfg.oen[i] && perm.oen_clr[i])
                    oen_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg.src     = src_q;
        cfg.rng     = rng_q;
        cfg.frac_en = frac_q;
        cfg.pre     = pre_q;
        cfg.bst     = bst_q;
        cfg.oen     = oen_q;
    end

    // R3: source frozen while the PLL runs
    a_r3_src_locked: assert property (@(posedge clk) disable iff (rst)
        (we && perm.src == 1'b0) |=> $stable(src_q));

    // R4: input prescaler frozen unless core is idle
    a_r4_pre_locked: assert property (@(posedge clk) disable iff (rst)
        (we && !perm.pre) |=> $stable(pre_q));

    // R5: booster prescaler frozen unless core idle and booster off
    a_r5_bst_locked: assert property (@(posedge clk) disable iff (rst)
        (we && !perm.bst) |=> $stable(bst_q));

    // R9: R enable survives a clear while it feeds the system clock
    a_r9_r_kept: assert property (@(posedge clk) disable iff (rst)
        (we && sysclk_sel && oen_q[OUT_R] && !wr_cfg.oen[OUT_R]) |=> oen_q[OUT_R]);

endmodule

// File: rtl/pllcfg_frac_strobe.sv
module pllcfg_frac_strobe (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic allow,
    input  logic wr_bit,
    input  logic cur_bit,
    output logic load
);

    logic rise;

    assign rise = we && allow && wr_bit && !cur_bit;

    always_ff @(posedge clk) begin
        if (rst)
            load <= 1'b0;
        else
            load <= rise;
    end

    // R7: the strobe never lasts two cycles
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

    // R7: during the strobe the latch enable is already set
    a_r7_level_set: assert property (@(posedge clk) disable iff (rst)
        load |-> cur_bit);

endmodule

// File: rtl/pllcfg_guard_reg.sv
module pllcfg_guard_reg
    import pllcfg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    output logic [REG_W-1:0]       rd_data,
    input  logic                   st_pll_on,
    input  logic                   st_pll_rdy,
    input  logic                   st_boost_mode,
    input  logic                   st_sysclk_sel,
    output logic [SRC_W-1:0]       ref_src,
    output logic                   range_hi,
    output logic [PRE_RATIO_W-1:0] pre_div_ratio,
    output logic [BST_RATIO_W-1:0] boost_div_ratio,
    output logic                   frac_load,
    output logic                   out_en_p,
    output logic                   out_en_q,
    output logic                   out_en_r
);

    status_t st;
    wperm_t  perm;
    cfg_t    wr_cfg;
    cfg_t    cfg;

    assign st     = '{pll_on: st_pll_on, pll_rdy: st_pll_rdy,
                      boost_mode: st_boost_mode, sysclk_sel: st_sysclk_sel};
    assign wr_cfg = word_to_cfg(wr_data);

    pllcfg_lock_ctrl u_lock (
        .st   (st),
        .perm (perm)
    );

    pllcfg_field_store u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_en),
        .wr_cfg     (wr_cfg),
        .perm       (perm),
        .sysclk_sel (st_sysclk_sel),
        .cfg        (cfg)
    );

    pllcfg_frac_strobe u_frac (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .allow   (perm.frac),
        .wr_bit  (wr_cfg.frac_en),
        .cur_bit (cfg.frac_en),
        .load    (frac_load)
    );

    assign rd_data         = cfg_to_word(cfg);
    assign ref_src         = cfg.src;
    assign range_hi        = (cfg.rng == RNG_HIGH_CODE);
    assign pre_div_ratio   = pre_ratio(cfg.pre);
    assign boost_div_ratio = bst_ratio(cfg.bst);
    assign out_en_p        = cfg.oen[0];
    assign out_en_q        = cfg.oen[1];
    assign out_en_r        = cfg.oen[OUT_R];

    // R8: P and Q enables follow every write
    a_r8_pq_follow: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (out_en_p == $past(wr_data[OEN_LSB]))
               && (out_en_q == $past(wr_data[OEN_LSB+1])));

    // R6: range field is always written
    a_r6_rng_follow: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[RNG_LSB +: RNG_W] == $past(wr_data[RNG_LSB +: RNG_W])));

endmodule

// File: tb/sim_pllcfg_guard_reg.sv
module sim_pllcfg_guard_reg;

    typedef struct packed {
        logic [31:0] rd;
        logic        fl;
        logic        rhi;
        logic [4:0]  pre;
        logic [4:0]  bst;
        logic        p, q, r;
        logic [1:0]  src;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        st_on = 1'b0, st_rdy = 1'b0, st_bm = 1'b0, st_sc = 1'b0;
    logic [1:0]  ref_src;
    logic        range_hi, frac_load, en_p, en_q, en_r;
    logic [4:0]  pre_ratio_o, bst_ratio_o;

    exp_t  q_exp[$];
    string q_tag[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    logic [1:0] m_src = 0, m_rng = 0;
    logic       m_frac = 0, m_p = 0, m_q = 0, m_r = 0;
    logic [3:0] m_pre = 0, m_bst = 0;

    always #10 clk = ~clk;

    pllcfg_guard_reg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .st_pll_on(st_on), .st_pll_rdy(st_rdy), .st_boost_mode(st_bm),
        .st_sysclk_sel(st_sc), .ref_src(ref_src), .range_hi(range_hi),
        .pre_div_ratio(pre_ratio_o), .boost_div_ratio(bst_ratio_o),
        .frac_load(frac_load), .out_en_p(en_p), .out_en_q(en_q), .out_en_r(en_r)
    );

    function automatic logic [31:0] mk(input logic [1:0] s, input logic [1:0] g,
                                       input logic f, input logic [3:0] pr,
                                       input logic [3:0] b, input logic [2:0] o);
        return {13'd0, o, b, pr, 3'd0, f, g, s};
    endfunction

    function automatic logic [4:0] exp_bst(input logic [3:0] c);
        if (c == 0) return 5'd1;
        if (c <= 8) return {c, 1'b0};
        return 5'd0;
    endfunction

    function automatic exp_t model_now(input logic fl);
        exp_t e;
        e.rd  = mk(m_src, m_rng, m_frac, m_pre, m_bst, {m_r, m_q, m_p});
        e.fl  = fl;
        e.rhi = (m_rng == 2'd3);
        e.pre = {1'b0, m_pre} + 5'd1;
        e.bst = exp_bst(m_bst);
        e.p = m_p; e.q = m_q; e.r = m_r;
        e.src = m_src;
        return e;
    endfunction

    // driver: one write cycle, then one idle cycle, each with an expected item
    task automatic do_write(input logic [31:0] d, input logic [3:0] st, input string tag);
        logic pulse;
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        {st_on, st_rdy, st_bm, st_sc} = st;
        pulse = d[4] && !m_frac;
        if (!st[3]) m_src = d[1:0];
        m_rng  = d[3:2];
        m_frac = d[4];
        if (!st[3] && !st[2]) m_pre = d[11:8];
        if (!st[3] && !st[2] && !st[1]) m_bst = d[15:12];
        m_p = d[16];
        m_q = d[17];
        if (d[18]) m_r = 1'b1;
        else if (!st[0]) m_r = 1'b0;
        @(posedge clk);
        q_exp.push_back(model_now(pulse)); q_tag.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '1;
        {st_on, st_rdy, st_bm, st_sc} = ~st;
        @(posedge clk);
        q_exp.push_back(model_now(1'b0)); q_tag.push_back({tag, " idle"});
    endtask

    // monitor: compares a popped item shortly after each edge
    always @(posedge clk) begin
        #5;
        if (q_exp.size() > 0) begin
            exp_t e, a;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = '{rd: rd_data, fl: frac_load, rhi: range_hi, pre: pre_ratio_o,
                  bst: bst_ratio_o, p: en_p, q: en_q, r: en_r, src: ref_src};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk);
        q_exp.push_back(model_now(1'b0)); q_tag.push_back("R1 reset");

        // R2/R8: full write with core idle
        do_write(mk(2, 1, 0, 5, 3, 3'b111), 4'b0000, "R2 R8 all fields");
        // R3 R4 R5 R6: PLL on locks src, pre, bst; range still moves
        do_write(mk(3, 3, 0, 15, 8, 3'b111), 4'b1000, "R3 R4 R5 R6 pll on");
        // R3 R4: ready alone -> src writes, prescaler held
        do_write(mk(1, 0, 0, 9, 6, 3'b111), 4'b0100, "R3 R4 ready only");
        // R4 R5: booster alone -> prescaler writes, booster held
        do_write(mk(1, 2, 0, 15, 7, 3'b111), 4'b0010, "R4 R5 boost only");
        // R5: booster codes at boundaries
        do_write(mk(1, 2, 0, 0, 8, 3'b111), 4'b0000, "R5 bst code 8");
        do_write(mk(1, 2, 0, 0, 9, 3'b111), 4'b0000, "R5 bst reserved 9");
        do_write(mk(0, 2, 0, 0, 0, 3'b111), 4'b0000, "R5 R3 bst bypass src none");
        // R7: strobe on rising edge only
        do_write(mk(0, 2, 1, 0, 0, 3'b111), 4'b1111, "R7 rise");
        do_write(mk(0, 2, 1, 0, 0, 3'b111), 4'b0000, "R7 hold at one");
        do_write(mk(0, 2, 0, 0, 0, 3'b111), 4'b0000, "R7 clear");
        do_write(mk(0, 2, 1, 0, 0, 3'b111), 4'b0000, "R7 second rise");
        // R9 R8: clears while R drives system clock
        do_write(mk(0, 2, 1, 0, 0, 3'b000), 4'b0001, "R9 R8 clear under sysclk");
        do_write(mk(0, 2, 1, 0, 0, 3'b000), 4'b0000, "R9 clear allowed");
        do_write(mk(0, 2, 1, 0, 0, 3'b100), 4'b0001, "R9 set under sysclk");
        // R10: status flips right after the write (driver inverts it in idle)
        do_write(mk(2, 1, 0, 4, 2, 3'b011), 4'b1111, "R10 locked then released");
        do_write(mk(3, 0, 0, 1, 1, 3'b000), 4'b0000, "R10 free then locked");
        // R2: reserved bits read zero
        do_write(32'hFFFF_FFFF, 4'b0000, "R2 R6 all ones");

        wait (q_exp.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule